// File: doc/BRIEF.md
# USB Host Command Register with Moderated Interrupt

This block is the software-writable command word of a USB 2.0 style host controller, together with the logic that paces the host interrupt. Software writes and reads a 32-bit word through a plain register port. The writable fields are:

- an interrupt pacing threshold, counted in microframes;
- an asynchronous-advance doorbell;
- two schedule enables, one for the asynchronous schedule and one for the periodic schedule. Each enable drives an output to the schedule engine.

Fields that are not implemented read as constants.

When software rings the doorbell, the schedule engine later answers with a one-cycle eviction handshake. The answer means the engine has dropped all of its cached asynchronous schedule state. On that answer the block raises an advance status flag, and then the hardware clears the doorbell. A microframe tick counter marks a boundary every threshold ticks. A pending advance event reaches the interrupt output only at such a boundary, and only while the interrupt enable input is high. The interrupt then stays high until software clears the flag through a separate clear strobe, or until the enable input falls.

Top module: `hc_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0x00080000, which is threshold code 08h in bits 23:16 and zero in all other bits. The schedule enables, the status flag and the interrupt are all 0.
- R2: A write changes the threshold field only when bits 23:16 carry 01h, 02h, 04h, 08h, 10h, 20h or 40h, meaning 1 to 64 microframes. Any other code, including 00h, leaves the previous threshold in place. The other fields of that same write still take effect.
- R3: Bits 31:24, 15:7 and 3:0 always read zero. The zero in bits 3:2 is the code for a fixed 1024-entry frame list.
- R4: Bit 5 is the asynchronous schedule enable and bit 4 is the periodic schedule enable. Each reads back the last written value and drives async_en_o or periodic_en_o from the cycle after the write.
- R5: A write with bit 6 = 1 sets the doorbell only if the asynchronous enable was already 1 before that write. Writing 0 to bit 6 has no effect on the doorbell, and neither does writing 1 while the doorbell is already set.
- R6: An eviction handshake while the doorbell is set raises the status flag at the next edge. The doorbell then clears one cycle later. A handshake while the doorbell is clear does nothing.
- R7: A status clear strobe clears the flag. If the flag is set and cleared in the same cycle, the set wins.
- R8: The tick counter produces a boundary on every tick that brings it to the threshold, and then restarts at zero. If the threshold is lowered below the current count, the next tick produces a boundary.
- R9: The interrupt rises at the edge of a boundary tick, and only when the status flag and the enable input are both 1. It stays high until the flag is cleared or the enable input falls, and it drops in the same cycle that either happens. Once dropped, it is not raised again before the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| sts_clr_i | input | 1 | Status flag clear strobe (write-1-to-clear) |
| adv_ie_i | input | 1 | Advance interrupt enable |
| uframe_tick_i | input | 1 | One pulse per 125 us microframe |
| evict_done_i | input | 1 | Schedule engine has evicted cached asynchronous state |
| async_en_o | output | 1 | Asynchronous schedule enable |
| periodic_en_o | output | 1 | Periodic schedule enable |
| adv_sts_o | output | 1 | Asynchronous advance status flag |
| irq_o | output | 1 | Host interrupt |

## Verification
On every cycle, the assertions check the following:
- the stored threshold is always a legal code;
- the constant bits of the read word stay at zero;
- the doorbell rises only while the asynchronous enable is already set, and falls only after the flag has been raised;
- a handshake with the doorbell set raises the flag;
- the interrupt is high only while both the flag and the enable input are high;
- the interrupt rises only after a tick.

Some behaviour depends on sequences and exact counts, so only the bench scenarios can show it. That covers the exact tick on which a boundary falls for thresholds 4, 1 and a lowered value; that an invalid code is ignored; the set-over-clear priority; and that the interrupt stays low after the enable returns until the next boundary.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned THR_W    = 8;
  localparam int unsigned THR_LSB  = 16;
  localparam int unsigned DB_BIT   = 6;
  localparam int unsigned ASE_BIT  = 5;
  localparam int unsigned PSE_BIT  = 4;
  localparam logic [THR_W-1:0] THR_RST  = 8'h08;
  localparam logic [THR_W-1:0] THR_MAXC = 8'h40;

  // legal pacing codes: a single set bit no higher than THR_MAXC
  function automatic logic thr_legal(input logic [THR_W-1:0] code);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < int'(THR_W); i++) ones += int'(code[i]);
    return (ones == 1) && (code <= THR_MAXC);
  endfunction
endpackage

// File: rtl/hc_cmd_fields.sv
module hc_cmd_fields
  import hc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [THR_W-1:0] thr_wdata_i,
  input  logic             ase_wdata_i,
  input  logic             pse_wdata_i,
  output logic [THR_W-1:0] thr_o,
  output logic             ase_o,
  output logic             pse_o
);
  logic [THR_W-1:0] thr_q;
  logic             ase_q, pse_q;
  logic             thr_ok;

  assign thr_ok = thr_legal(thr_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_RST;
      ase_q <= 1'b0;
      pse_q <= 1'b0;
    end else if (wr_i) begin
      if (thr_ok) thr_q <= thr_wdata_i;
      ase_q <= ase_wdata_i;
      pse_q <= pse_wdata_i;
    end
  end

  assign thr_o = thr_q;
  assign ase_o = ase_q;
  assign pse_o = pse_q;
endmodule

// File: rtl/hc_cmd_doorbell.sv
module hc_cmd_doorbell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_i,
  input  logic ase_i,
  input  logic evict_i,
  input  logic sts_clr_i,
  output logic db_o,
  output logic sts_o
);
  logic db_q, ack_q, sts_q;
  logic evict_hit;

  assign evict_hit = evict_i && db_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (ack_q) begin
      // flag already raised on the previous edge
      db_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (evict_hit) begin
      ack_q <= 1'b1;
    end else if (ring_i && ase_i && !db_q) begin
      db_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sts_q <= 1'b0;
    else if (evict_hit) sts_q <= 1'b1;
    else if (sts_clr_i) sts_q <= 1'b0;
  end

  assign db_o  = db_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/hc_cmd_uframe_timer.sv
module hc_cmd_uframe_timer
  import hc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             bound_o
);
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_nx;

  assign cnt_nx  = {1'b0, cnt_q} + 1'b1;
  assign bound_o = tick_i && (cnt_nx >= {1'b0, thr_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (bound_o) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_nx[THR_W-1:0];
  end
endmodule

// File: rtl/hc_cmd_irq_gate.sv
module hc_cmd_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bound_i,
  input  logic sts_i,
  input  logic ie_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (irq_q || bound_i) && sts_i && ie_i;
  end

  // drop at once when flag or enable goes away
  assign irq_o = irq_q && sts_i && ie_i;
endmodule

// File: rtl/hc_cmd_ctrl.sv
module hc_cmd_ctrl
  import hc_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sts_clr_i,
  input  logic              adv_ie_i,
  input  logic              uframe_tick_i,
  input  logic              evict_done_i,
  output logic              async_en_o,
  output logic              periodic_en_o,
  output logic              adv_sts_o,
  output logic              irq_o
);
  logic [THR_W-1:0] thr;
  logic             ase, pse, db, sts, bound;
  logic             unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[DATA_W-1:THR_LSB+THR_W],
                          reg_wdata_i[THR_LSB-1:DB_BIT+1],
                          reg_wdata_i[PSE_BIT-1:0]};

  hc_cmd_fields u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .thr_wdata_i (reg_wdata_i[THR_LSB+:THR_W]),
    .ase_wdata_i (reg_wdata_i[ASE_BIT]),
    .pse_wdata_i (reg_wdata_i[PSE_BIT]),
    .thr_o       (thr),
    .ase_o       (ase),
    .pse_o       (pse)
  );

  hc_cmd_doorbell u_db (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ring_i    (reg_wr_i && reg_wdata_i[DB_BIT]),
    .ase_i     (ase),
    .evict_i   (evict_done_i),
    .sts_clr_i (sts_clr_i),
    .db_o      (db),
    .sts_o     (sts)
  );

  hc_cmd_uframe_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (uframe_tick_i),
    .thr_i   (thr),
    .bound_o (bound)
  );

  hc_cmd_irq_gate u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bound_i (bound),
    .sts_i   (sts),
    .ie_i    (adv_ie_i),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o                     = '0;
    reg_rdata_o[THR_LSB+:THR_W]     = thr;
    reg_rdata_o[DB_BIT]             = db;
    reg_rdata_o[ASE_BIT]            = ase;
    reg_rdata_o[PSE_BIT]            = pse;
  end

  assign async_en_o    = ase;
  assign periodic_en_o = pse;
  assign adv_sts_o     = sts;
endmodule

// File: rtl/hc_cmd_ctrl_chk.sv
module hc_cmd_ctrl_chk
  import hc_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              adv_ie_i,
  input logic              uframe_tick_i,
  input logic              evict_done_i,
  input logic              async_en_o,
  input logic              adv_sts_o,
  input logic              irq_o
);
  logic [THR_W-1:0] thr_rd;
  logic             db_rd;
  assign thr_rd = reg_rdata_o[THR_LSB+:THR_W];
  assign db_rd  = reg_rdata_o[DB_BIT];

  a_r2_thr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(thr_rd) && (thr_rd <= THR_MAXC));

  a_r3_const_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[31:24] == 8'h00) && (reg_rdata_o[15:7] == 9'h000) && (reg_rdata_o[3:0] == 4'h0));

  a_r5_db_needs_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(db_rd) |-> $past(async_en_o));

  a_r6_db_clear_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(db_rd) |-> $past(adv_sts_o));

  a_r6_evict_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_done_i && db_rd) |=> adv_sts_o);

  a_r9_irq_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (adv_sts_o && adv_ie_i));

  a_r9_irq_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(uframe_tick_i));
endmodule

bind hc_cmd_ctrl hc_cmd_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_rdata_o   (reg_rdata_o),
  .adv_ie_i      (adv_ie_i),
  .uframe_tick_i (uframe_tick_i),
  .evict_done_i  (evict_done_i),
  .async_en_o    (async_en_o),
  .adv_sts_o     (adv_sts_o),
  .irq_o         (irq_o)
);

// File: tb/hc_cmd_ctrl_bench.sv
module hc_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sts_clr = 1'b0, adv_ie = 1'b1, tick = 1'b0, evict = 1'b0;
  logic        async_en, periodic_en, adv_sts, irq;

  always #2 clk = ~clk;

  hc_cmd_ctrl u_hc_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .sts_clr_i(sts_clr), .adv_ie_i(adv_ie),
    .uframe_tick_i(tick), .evict_done_i(evict), .async_en_o(async_en),
    .periodic_en_o(periodic_en), .adv_sts_o(adv_sts), .irq_o(irq)
  );

  typedef struct {
    int          sel;  // 0 rdata, 1 async, 2 periodic, 3 flag, 4 irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic expect_v(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = reg_rdata;
        1: act = {31'b0, async_en};
        2: act = {31'b0, periodic_en};
        3: act = {31'b0, adv_sts};
        default: act = {31'b0, irq};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic pulse_evict(input logic clr);
    @(negedge clk); evict = 1'b1; sts_clr = clr;
    @(negedge clk); evict = 1'b0; sts_clr = 1'b0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask
  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    expect_v(0, 32'h0008_0000, "R1 reset value");
    expect_v(1, 0, "R1 async after reset");
    expect_v(3, 0, "R1 flag after reset");
    expect_v(4, 0, "R1 irq after reset");

    wr(32'h0004_0030);
    expect_v(0, 32'h0004_0030, "R4 enables and threshold");
    expect_v(1, 1, "R4 async_en_o");
    expect_v(2, 1, "R4 periodic_en_o");
    wr(32'h0003_0010);
    expect_v(0, 32'h0004_0010, "R2 code 03h ignored");
    wr(32'h0000_0030);
    expect_v(0, 32'h0004_0030, "R2 code 00h ignored");
    wr(32'hFFFF_FFBF);
    expect_v(0, 32'h0004_0030, "R3 constant bits stay zero");

    wr(32'h0004_0010);
    wr(32'h0004_0050);
    expect_v(0, 32'h0004_0010, "R5 doorbell refused with async off");
    wr(32'h0004_0030);
    wr(32'h0004_0070);
    expect_v(0, 32'h0004_0070, "R5 doorbell set");
    wr(32'h0004_0030);
    expect_v(0, 32'h0004_0070, "R5 write 0 keeps doorbell");
    wr(32'h0004_0070);
    expect_v(0, 32'h0004_0070, "R5 write 1 while set");

    @(negedge clk); evict = 1'b1;
    @(negedge clk); evict = 1'b0;
    expect_v(3, 1, "R6 flag raised");
    expect_v(0, 32'h0004_0070, "R6 doorbell still set one cycle");
    idle();
    expect_v(0, 32'h0004_0030, "R6 doorbell cleared");

    ticks(3);
    expect_v(4, 0, "R8 no boundary after 3 ticks");
    ticks(1);
    expect_v(4, 1, "R9 irq at 4th tick");
    idle(); idle();
    expect_v(4, 1, "R9 irq held");
    pulse_clr();
    expect_v(3, 0, "R7 flag cleared");
    expect_v(4, 0, "R9 irq drops with flag");

    pulse_evict(1'b0);
    expect_v(3, 0, "R6 evict ignored with doorbell clear");

    wr(32'h0004_0070);
    pulse_evict(1'b0);
    idle();
    ticks(4);
    expect_v(4, 1, "R9 irq second boundary");
    @(negedge clk); adv_ie = 1'b0;
    idle();
    expect_v(4, 0, "R9 irq drops with enable");
    @(negedge clk); adv_ie = 1'b1;
    idle();
    expect_v(4, 0, "R9 irq waits for next boundary");
    ticks(4);
    expect_v(4, 1, "R9 irq after next boundary");
    pulse_clr();

    wr(32'h0001_0070);
    pulse_evict(1'b0);
    idle();
    ticks(1);
    expect_v(4, 1, "R8 threshold 1 boundary each tick");
    pulse_clr();

    wr(32'h0008_0070);
    pulse_evict(1'b1);
    expect_v(3, 1, "R7 set wins over clear");
    idle();
    ticks(3);
    expect_v(4, 0, "R8 no boundary at 3 of 8");
    wr(32'h0002_0030);
    ticks(1);
    expect_v(4, 1, "R8 lowered threshold boundary");

    idle(); idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule